// File: doc/BRIEF.md
# Switch Egress Tag Inserter

This block sits in the transmit path between a host CPU and a managed Ethernet switch. Frames arrive one byte per cycle on a valid/ready stream with an end-of-frame marker. Along with the first byte of each frame, the host supplies a destination front-panel index, a priority and a control code. The block copies the destination and source MAC addresses unchanged. After them it places a two-byte switch tag, ahead of the EtherType. The rest of the frame follows unchanged. The switch reads the tag to decide where the frame goes.

The tag carries a fixed version code, a flag that marks the frame as coming from the CPU, the priority and control codes, and a seven-bit destination map with at most one bit set. Front-panel index n selects map bit n+1. Map bit 0 stands for the CPU port and is never set by this block. An index outside the supported range leaves the map empty and raises a one-cycle error pulse. The frame is still sent. Input bytes are held back while the tag goes out, so no byte is dropped.

Top module: `sw_tag_inserter`

## Requirements
- R1: Bytes 0 to 11 of each input frame leave the block unchanged and in order, as the first 12 output bytes.
- R2: When a frame is longer than 12 bytes, two tag bytes follow output byte 11, most significant byte first. After them come input bytes 12 onward, unchanged. The output length is the input length plus 2.
- R3: Tag bits 15:14 hold the version code 2'b10, and tag bit 7 (the from-CPU flag) is 1 in every tag.
- R4: Tag bits 13:11 hold the priority and bits 10:8 hold the control code. Both, together with the destination index, are taken on the cycle the first byte of the frame is accepted. Later changes within the frame have no effect on the tag.
- R5: Tag bits 6:0 form the destination map. For a destination index n in 0..4, exactly bit n+1 is set. All other bits are 0.
- R6: A destination index of 5 to 7 gives an all-zero map. `bad_dest` is then high for exactly the cycle after the first byte is accepted, and the frame is still forwarded in full. A valid index never raises `bad_dest`.
- R7: `s_ready` is low on every cycle in which a tag byte is offered. `m_last` is never set on a tag byte, and it is set only on the byte that carried `s_last`.
- R8: While `m_ready` is low, the offered tag byte stays the same until it is taken. Outside the tag, `s_ready` follows `m_ready`.
- R9: A frame whose last byte falls within its first 12 bytes passes through unchanged, with no tag. The next frame is handled from its own first byte.
- R10: After reset, with no input offered, `m_valid` and `bad_dest` are low and the block waits for the first byte of a frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| s_valid | input | 1 | Input byte valid |
| s_ready | output | 1 | Block accepts the input byte |
| s_data | input | 8 | Input frame byte |
| s_last | input | 1 | Input byte ends the frame |
| s_dport | input | 3 | Destination front-panel index, taken with the first byte |
| s_prio | input | 3 | Frame priority, taken with the first byte |
| s_ctrl | input | 3 | Control code, taken with the first byte |
| m_valid | output | 1 | Output byte valid |
| m_ready | input | 1 | Downstream accepts the output byte |
| m_data | output | 8 | Output frame byte |
| m_last | output | 1 | Output byte ends the frame |
| bad_dest | output | 1 | One-cycle pulse: destination index out of range |

## Verification
The frames vary in length: well above 12 bytes, exactly 13 (a tag followed by a single body byte), exactly 12 and 1 (both short, so no tag), and a long frame straight after a short one to show that the byte count restarts. The header values are chosen so that every field is told apart from its neighbours. They include all-zero priority and control, all-ones priority and control, each boundary destination index, and out-of-range indices. The sideband inputs are changed after the first byte on every frame, which shows that they are latched only once. Gaps on the input side and stalls on the output side are applied both alone and together, so that holding the tag, back-pressure, and the placement of the end marker can each be seen apart from the basic insertion order.

// File: rtl/sw_tag_pkg.sv
package sw_tag_pkg;
   typedef enum logic [1:0] {
      ST_ADDR   = 2'd0,
      ST_TAG_HI = 2'd1,
      ST_TAG_LO = 2'd2,
      ST_BODY   = 2'd3
   } ins_state_t;

   localparam int VER_W = 2;
endpackage

// File: rtl/sw_tag_builder.sv
module sw_tag_builder
   import sw_tag_pkg::*;
#(
   parameter int PORT_W      = 3,
   parameter int PRIO_W      = 3,
   parameter int CTRL_W      = 3,
   parameter int MAP_W       = 7,
   parameter int NUM_FRONT   = 5,
   parameter int VERSION     = 2,
   parameter bit SIDEBAND_EN = 1'b1,
   localparam int TAG_W      = VER_W + PRIO_W + CTRL_W + 1 + MAP_W
) (
   input  logic [PORT_W-1:0] dport,
   input  logic [PRIO_W-1:0] prio,
   input  logic [CTRL_W-1:0] ctrl,
   output logic [TAG_W-1:0]  tag,
   output logic              bad_port
);
   logic [MAP_W-1:0]  dest_map;
   logic [PRIO_W-1:0] prio_f;
   logic [CTRL_W-1:0] ctrl_f;

   if (NUM_FRONT + 1 > MAP_W) begin : g_chk_map
      $error("sw_tag_builder: map too narrow for front ports");
   end
   if (NUM_FRONT > (1 << PORT_W)) begin : g_chk_port
      $error("sw_tag_builder: index width too small");
   end
   if (VERSION >= (1 << VER_W)) begin : g_chk_ver
      $error("sw_tag_builder: version code does not fit");
   end

   // map bit 0 is the CPU port; front index n selects bit n+1
   for (genvar b = 0; b < MAP_W; b++) begin : g_map
      if (b >= 1 && b <= NUM_FRONT) begin : g_port
         assign dest_map[b] = (dport == PORT_W'(b - 1));
      end else begin : g_zero
         assign dest_map[b] = 1'b0;
      end
   end

   if (SIDEBAND_EN) begin : g_sideband
      assign prio_f = prio;
      assign ctrl_f = ctrl;
   end else begin : g_no_sideband
      assign prio_f = '0;
      assign ctrl_f = '0;
   end

   assign bad_port = ~|dest_map;
   assign tag      = {VER_W'(VERSION), prio_f, ctrl_f, 1'b1, dest_map};
endmodule

// File: rtl/sw_tag_seq.sv
module sw_tag_seq
   import sw_tag_pkg::*;
#(
   parameter int ADDR_BYTES = 12,
   localparam int CNT_W     = $clog2(ADDR_BYTES + 1)
) (
   input  logic clk,
   input  logic rst_n,
   input  logic in_fire,
   input  logic in_last,
   input  logic out_fire,
   output logic frame_start,
   output logic tag_hi,
   output logic tag_lo
);
   ins_state_t       state;
   logic [CNT_W-1:0] cnt;

   if (ADDR_BYTES < 1) begin : g_chk_addr
      $error("sw_tag_seq: address span must be at least one byte");
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state <= ST_ADDR;
         cnt   <= '0;
      end else begin
         unique case (state)
            ST_ADDR: begin
               if (in_fire) begin
                  if (in_last) begin
                     cnt <= '0;
                  end else if (cnt == CNT_W'(ADDR_BYTES - 1)) begin
                     cnt   <= '0;
                     state <= ST_TAG_HI;
                  end else begin
                     cnt <= cnt + 1'b1;
                  end
               end
            end
            ST_TAG_HI: if (out_fire) state <= ST_TAG_LO;
            ST_TAG_LO: if (out_fire) state <= ST_BODY;
            ST_BODY:   if (in_fire && in_last) state <= ST_ADDR;
            default:   state <= ST_ADDR;
         endcase
      end
   end

   assign frame_start = (state == ST_ADDR) && (cnt == '0);
   assign tag_hi      = (state == ST_TAG_HI);
   assign tag_lo      = (state == ST_TAG_LO);

   // R1
   cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cnt <= CNT_W'(ADDR_BYTES - 1));

   // R2
   tag_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_TAG_LO) |-> ($past(state) == ST_TAG_HI || $past(state) == ST_TAG_LO));
endmodule

// File: rtl/sw_tag_inserter.sv
module sw_tag_inserter
   import sw_tag_pkg::*;
#(
   parameter int DATA_W      = 8,
   parameter int ADDR_BYTES  = 12,
   parameter int PORT_W      = 3,
   parameter int PRIO_W      = 3,
   parameter int CTRL_W      = 3,
   parameter int MAP_W       = 7,
   parameter int NUM_FRONT   = 5,
   parameter int VERSION     = 2,
   parameter bit SIDEBAND_EN = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              s_valid,
   output logic              s_ready,
   input  logic [DATA_W-1:0] s_data,
   input  logic              s_last,
   input  logic [PORT_W-1:0] s_dport,
   input  logic [PRIO_W-1:0] s_prio,
   input  logic [CTRL_W-1:0] s_ctrl,
   output logic              m_valid,
   input  logic              m_ready,
   output logic [DATA_W-1:0] m_data,
   output logic              m_last,
   output logic              bad_dest
);
   localparam int TAG_W = VER_W + PRIO_W + CTRL_W + 1 + MAP_W;

   if (TAG_W != 2 * DATA_W) begin : g_chk_tag
      $error("sw_tag_inserter: tag must be exactly two data beats");
   end

   logic [TAG_W-1:0] tag_new, tag_q;
   logic             bad_new, bad_q;
   logic             frame_start, tag_hi, tag_lo, in_tag;
   logic             in_fire, out_fire;

   sw_tag_builder #(
      .PORT_W(PORT_W), .PRIO_W(PRIO_W), .CTRL_W(CTRL_W), .MAP_W(MAP_W),
      .NUM_FRONT(NUM_FRONT), .VERSION(VERSION), .SIDEBAND_EN(SIDEBAND_EN)
   ) builder_i (
      .dport(s_dport), .prio(s_prio), .ctrl(s_ctrl),
      .tag(tag_new), .bad_port(bad_new)
   );

   sw_tag_seq #(.ADDR_BYTES(ADDR_BYTES)) seq_i (
      .clk(clk), .rst_n(rst_n),
      .in_fire(in_fire), .in_last(s_last), .out_fire(out_fire),
      .frame_start(frame_start), .tag_hi(tag_hi), .tag_lo(tag_lo)
   );

   assign in_tag   = tag_hi | tag_lo;
   assign in_fire  = s_valid & s_ready;
   assign out_fire = m_valid & m_ready;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         tag_q <= '0;
         bad_q <= 1'b0;
      end else begin
         bad_q <= in_fire & frame_start & bad_new;
         if (in_fire && frame_start) tag_q <= tag_new;
      end
   end

   always_comb begin
      if (in_tag) begin
         m_valid = 1'b1;
         m_data  = tag_hi ? tag_q[TAG_W-1 -: DATA_W] : tag_q[DATA_W-1:0];
         m_last  = 1'b0;
         s_ready = 1'b0;
      end else begin
         m_valid = s_valid;
         m_data  = s_data;
         m_last  = s_last;
         s_ready = m_ready;
      end
   end

   assign bad_dest = bad_q;

   // R3
   tag_ver_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (tag_hi && m_valid) |-> (m_data[DATA_W-1 -: VER_W] == VER_W'(VERSION)));

   // R3
   tag_cpu_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (tag_lo && m_valid) |-> m_data[MAP_W]);

   // R5
   map_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
      tag_lo |-> ($onehot0(m_data[MAP_W-1:0]) && !m_data[0]));

   // R7
   tag_no_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
      in_tag |-> (!m_last && !s_ready));

   // R8
   tag_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (in_tag && !m_ready) |=> (in_tag && $stable(m_data)));

   // R6
   bad_after_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
      bad_dest |-> $past(s_valid && s_ready));
endmodule

// File: tb/sw_tag_inserter_tb_top.sv
module sw_tag_inserter_tb_top;
   localparam int CLK_P = 10;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       s_valid = 1'b0, s_ready, s_last = 1'b0;
   logic [7:0] s_data = '0;
   logic [2:0] s_dport = '0, s_prio = '0, s_ctrl = '0;
   logic       m_valid, m_ready = 1'b1, m_last;
   logic [7:0] m_data;
   logic       bad_dest;

   int total = 0;
   int bad   = 0;
   int cyc   = 0;

   always #(CLK_P/2) clk = ~clk;

   sw_tag_inserter dut_i (
      .clk(clk), .rst_n(rst_n),
      .s_valid(s_valid), .s_ready(s_ready), .s_data(s_data), .s_last(s_last),
      .s_dport(s_dport), .s_prio(s_prio), .s_ctrl(s_ctrl),
      .m_valid(m_valid), .m_ready(m_ready), .m_data(m_data), .m_last(m_last),
      .bad_dest(bad_dest)
   );

   function automatic logic [7:0] fbyte(int seed, int i);
      return 8'((seed * 31 + i * 13 + 5) & 255);
   endfunction

   function automatic logic [15:0] exp_tag(int d, int p, int c);
      logic [6:0] map;
      map = (d < 5) ? 7'(1 << (d + 1)) : 7'd0;
      return {2'b10, 3'(p), 3'(c), 1'b1, map};
   endfunction

   task automatic check(input bit ok, input string req, input string what,
                        input int act, input int expv);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s %s: actual=0x%0h expected=0x%0h", req, what, act, expv);
      end
   endtask

   task automatic reset_check();
      rst_n = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      #1;
      // R10
      check(!m_valid, "R10", "m_valid after reset", int'(m_valid), 0);
      check(!bad_dest, "R10", "bad_dest after reset", int'(bad_dest), 0);
      check(s_ready == m_ready, "R8", "s_ready follows m_ready idle", int'(s_ready), int'(m_ready));
   endtask

   // one frame: in_gap / out_stall of 0 means no gaps / stalls
   task automatic run_frame(input int len, input int d, input int p, input int c,
                            input int in_gap, input int out_stall, input int seed);
      logic [7:0] ob [0:63];
      logic       ol [0:63];
      logic [7:0] eb [0:63];
      logic       el [0:63];
      logic [15:0] tg;
      int  exp_len, in_idx, out_n, waits, err_cnt, last_cnt;
      bit  presenting, prev_first, err_late, rdy_bad, data_ok, addr_ok;

      tg      = exp_tag(d, p, c);
      exp_len = (len > 12) ? len + 2 : len;
      for (int i = 0; i < exp_len; i++) begin
         if (len <= 12 || i < 12) eb[i] = fbyte(seed, i);
         else if (i == 12) eb[i] = tg[15:8];
         else if (i == 13) eb[i] = tg[7:0];
         else eb[i] = fbyte(seed, i - 2);
         el[i] = (i == exp_len - 1);
      end

      in_idx = 0; out_n = 0; waits = 0; err_cnt = 0;
      presenting = 0; prev_first = 0; err_late = 0; rdy_bad = 0;
      while (out_n < exp_len && waits < 3000) begin
         @(negedge clk);
         if (bad_dest) begin
            err_cnt++;
            if (!prev_first) err_late = 1;
         end
         prev_first = 0;
         if (!presenting && in_idx < len)
            presenting = (in_gap == 0) || ((cyc % in_gap) != 0);
         s_valid = presenting;
         s_data  = fbyte(seed, in_idx);
         s_last  = (in_idx == len - 1);
         // R4: sideband scrambled after the first byte
         s_dport = (in_idx == 0) ? 3'(d) : ~3'(d);
         s_prio  = (in_idx == 0) ? 3'(p) : ~3'(p);
         s_ctrl  = (in_idx == 0) ? 3'(c) : ~3'(c);
         m_ready = (out_stall == 0) || ((cyc % out_stall) != 0);
         #1;
         if (len > 12 && (out_n == 12 || out_n == 13) && m_valid && s_ready) rdy_bad = 1;
         if (m_valid && m_ready) begin
            ob[out_n] = m_data;
            ol[out_n] = m_last;
            out_n++;
         end
         if (s_valid && s_ready) begin
            if (in_idx == 0) prev_first = 1;
            in_idx++;
            presenting = 0;
         end
         cyc++;
         waits++;
      end
      @(negedge clk);
      s_valid = 1'b0;
      s_last  = 1'b0;
      if (bad_dest) begin
         err_cnt++;
         if (!prev_first) err_late = 1;
      end

      check(out_n == exp_len, (len > 12) ? "R2" : "R9", "output length", out_n, exp_len);
      addr_ok = 1; data_ok = 1; last_cnt = 0;
      for (int i = 0; i < out_n; i++) begin
         if (ob[i] != eb[i]) begin
            if (i < 12) addr_ok = 0; else if (i > 13) data_ok = 0;
         end
         if (ol[i] != el[i]) last_cnt++;
      end
      check(addr_ok, "R1", "address bytes", int'(ob[0]), int'(eb[0]));
      if (len > 12) begin
         check({ob[12], ob[13]} == tg, "R3 R4 R5", "tag value", int'({ob[12], ob[13]}), int'(tg));
         check(data_ok, "R2", "body bytes", int'(ob[exp_len-1]), int'(eb[exp_len-1]));
         check(!rdy_bad, "R7", "s_ready low during tag", int'(rdy_bad), 0);
      end else begin
         check(data_ok, "R9", "short frame bytes", int'(ob[0]), int'(eb[0]));
      end
      check(last_cnt == 0, "R7", "end marker placement errors", last_cnt, 0);
      check(err_cnt == ((d > 4) ? 1 : 0) && !err_late, "R6", "bad_dest pulses",
            err_cnt, (d > 4) ? 1 : 0);
   endtask

   initial begin
      #(CLK_P * 150000);
      bad++;
      total++;
      $display("FAIL watchdog: actual=timeout expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      reset_check();
      run_frame(20, 0, 0, 0, 0, 0, 1);   // R5 index 0 -> bit 1
      run_frame(16, 4, 5, 3, 0, 0, 2);   // R5 index 4 -> bit 5, R4 fields
      run_frame(13, 2, 7, 7, 0, 3, 3);   // R8 output stalls on tag
      run_frame(30, 6, 1, 2, 3, 0, 4);   // R6 bad index, input gaps
      run_frame(5,  1, 2, 2, 0, 0, 5);   // R9 short frame
      run_frame(12, 3, 4, 4, 0, 2, 6);   // R9 exactly address length
      run_frame(14, 1, 6, 5, 0, 0, 7);   // R9 restart after short frame
      run_frame(1,  7, 0, 0, 0, 0, 8);   // R6 bad index on one-byte frame
      run_frame(40, 3, 2, 1, 4, 3, 9);   // R2 R8 both-side stalls
      run_frame(18, 5, 3, 6, 0, 2, 10);  // R6 first out-of-range index
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule